// File: doc/BRIEF.md
# Prioritized Five-Source Interrupt Controller

This block sits next to a small 8-bit processor core. At each instruction boundary it decides whether one hardware interrupt is taken. There are five request lines. The first is a non-maskable line that needs both an edge and a level. The second is a maskable line that latches a rising edge. Two maskable lines are level-sensitive. The last is a general request that carries no vector. A global enable flip-flop gates every source except the non-maskable one. The core sets that flip-flop with one strobe and clears it with another. Per-source masks are loaded from a data word through a mask-write strobe.

The core raises `boundary_i` for one cycle when it is ready to sample requests. If a source qualifies in that cycle, the controller sends out a one-cycle acceptance on the next cycle. The acceptance carries the winning source and its fixed vector address. For the general request it carries an acknowledge instead, and the requesting device supplies the target itself. The acceptance is an event and cannot be refused, so it has no ready signal and no back-pressure. A status byte on `status_o` can be read at any time. It shows the masks, the global enable and the pending state of the three maskable vectored sources.

Top module: `irqc_top`

## Requirements
- R1: After reset the global enable is 0, all three masks are set (masked), the edge latch and the non-maskable arm are cleared, `take_o` and `gen_ack_o` are 0, and `status_o` reads 8'h07.
- R2: A pulse on `ien_set_i` sets the global enable and a pulse on `ien_clr_i` clears it. If both are high in the same cycle, clear wins. The enable is visible in `status_o[3]` on the cycle after the strobe.
- R3: A write with `mask_wr_i` loads `mask_data_i[2:0]` into the masks only when `mask_data_i[3]` is 1. Bit 2 masks the edge source, bit 1 masks level source A and bit 0 masks level source B, and 1 means masked. When `mask_data_i[4]` is 1, the edge latch is cleared. `status_o[2:0]` shows the masks.
- R4: A rising edge on `req_edge_i` sets the edge latch, and the latch stays set after the input falls. `status_o[6]` shows the latch.
- R5: Level sources A and B and the general request are considered only while their input is high in the boundary cycle. `status_o[5]` and `status_o[4]` show the raw levels of A and B. `status_o[7]` reads 0.
- R6: The non-maskable source is accepted at a boundary only if a rising edge has been seen since its last acceptance and the input is still high. If the input falls first, the request is dropped. This source ignores the global enable and the masks.
- R7: Priority from highest to lowest is non-maskable, edge, level A, level B, general. Exactly one source is taken per boundary.
- R8: On the cycle after an accepting boundary, `take_o` pulses for one cycle. `src_o` carries the source code: 0 non-maskable, 1 edge, 2 level A, 3 level B, 4 general. `vec_o` carries 16'h0024, 16'h003C, 16'h0034 or 16'h002C for the four vectored sources. For the general request, `gen_ack_o` pulses and `vec_o` is 0.
- R9: Any acceptance clears the global enable, and acceptance wins over a set strobe in the same cycle. Accepting the edge source clears its latch.
- R10: No acceptance happens in a cycle without a boundary, even when requests are pending.
- R11: A maskable source that is masked, or that arrives while the global enable is 0, is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_nmi_i | input | 1 | Non-maskable request (edge and level) |
| req_edge_i | input | 1 | Maskable request, rising edge latched |
| req_lvl_a_i | input | 1 | Maskable level request A |
| req_lvl_b_i | input | 1 | Maskable level request B |
| req_gen_i | input | 1 | General non-vectored request |
| boundary_i | input | 1 | Instruction-boundary sampling strobe |
| ien_set_i | input | 1 | Set global enable |
| ien_clr_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask-word write strobe |
| mask_data_i | input | 8 | Mask word |
| status_o | output | 8 | Status byte |
| take_o | output | 1 | Acceptance pulse |
| src_o | output | 3 | Accepted source code |
| vec_o | output | 16 | Vector address of the accepted source |
| gen_ack_o | output | 1 | Acknowledge for the general request |

## Verification
The hardest situations to reach are the ones where the non-maskable line and a pending edge latch race against other state. One case is a non-maskable pulse that falls before any boundary. Another is a line that is still high from an earlier acceptance, which must not fire again. A third is a non-maskable request that arrives while the edge latch is pending and the enable is on. The bench reaches these by driving the request lines cycle by cycle around the boundary strobe. It then reads the status byte to confirm that the losing edge request is still latched after the non-maskable one wins.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int VEC_W   = 16;
  localparam int DATA_W  = 8;
  localparam int MASK_N  = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NMI  = 3'd0,
    SRC_EDGE = 3'd1,
    SRC_LVLA = 3'd2,
    SRC_LVLB = 3'd3,
    SRC_GEN  = 3'd4
  } src_e;

  localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_LVLA = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_LVLB = 16'h002C;

  function automatic logic [VEC_W-1:0] vec_of(src_e s);
    case (s)
      SRC_NMI:  return VEC_NMI;
      SRC_EDGE: return VEC_EDGE;
      SRC_LVLA: return VEC_LVLA;
      SRC_LVLB: return VEC_LVLB;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sense.sv
// Input conditioning for the two edge-qualified sources.
module irqc_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic req_nmi,
  input  logic req_edge,
  input  logic clr_nmi,
  input  logic clr_edge,
  output logic nmi_arm,
  output logic edge_pend
);
  logic nmi_q, edge_q;
  logic nmi_rise, edge_rise;

  assign nmi_rise  = req_nmi  & ~nmi_q;
  assign edge_rise = req_edge & ~edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q     <= 1'b0;
      edge_q    <= 1'b0;
      nmi_arm   <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      nmi_q     <= req_nmi;
      edge_q    <= req_edge;
      // armed by a rise, dropped when the line falls or on acceptance
      nmi_arm   <= nmi_rise | (nmi_arm & req_nmi & ~clr_nmi);
      // a fresh rise beats a clear in the same cycle
      edge_pend <= edge_rise | (edge_pend & ~clr_edge);
    end
  end
endmodule

// File: rtl/irqc_ctrl_regs.sv
// Global enable flip-flop and per-source masks.
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int MN = MASK_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien_set,
  input  logic          ien_clr,
  input  logic          accept,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_data,
  output logic          ien,
  output logic [MN-1:0] mask,
  output logic          edge_clr_cmd
);
  localparam int LOAD_BIT = MN;
  localparam int CLR_BIT  = MN + 1;

  assign edge_clr_cmd = mask_wr & mask_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      mask <= '1;
    end else begin
      if (accept)       ien <= 1'b0;
      else if (ien_clr) ien <= 1'b0;
      else if (ien_set) ien <= 1'b1;
      if (mask_wr && mask_data[LOAD_BIT]) mask <= mask_data[MN-1:0];
    end
  end
endmodule

// File: rtl/irqc_prio.sv
// Fixed priority pick: lowest index wins.
module irqc_prio #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_nmi_i,
  input  logic              req_edge_i,
  input  logic              req_lvl_a_i,
  input  logic              req_lvl_b_i,
  input  logic              req_gen_i,
  input  logic              boundary_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic              take_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              gen_ack_o
);
  logic              nmi_arm, edge_pend, ien, edge_clr_cmd;
  logic [MASK_N-1:0] mask;
  logic [NSRC-1:0]   elig;
  logic              any;
  logic [SRC_W-1:0]  win_idx;
  src_e              win;
  logic              accept;

  assign win    = src_e'(win_idx);
  assign accept = boundary_i & any;

  irqc_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_nmi   (req_nmi_i),
    .req_edge  (req_edge_i),
    .clr_nmi   (accept && win == SRC_NMI),
    .clr_edge  ((accept && win == SRC_EDGE) || edge_clr_cmd),
    .nmi_arm   (nmi_arm),
    .edge_pend (edge_pend)
  );

  irqc_ctrl_regs #(.DW(DATA_W), .MN(MASK_N)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ien_set      (ien_set_i),
    .ien_clr      (ien_clr_i),
    .accept       (accept),
    .mask_wr      (mask_wr_i),
    .mask_data    (mask_data_i),
    .ien          (ien),
    .mask         (mask),
    .edge_clr_cmd (edge_clr_cmd)
  );

  always_comb begin
    elig           = '0;
    elig[SRC_NMI]  = nmi_arm & req_nmi_i;
    elig[SRC_EDGE] = edge_pend   & ~mask[2] & ien;
    elig[SRC_LVLA] = req_lvl_a_i & ~mask[1] & ien;
    elig[SRC_LVLB] = req_lvl_b_i & ~mask[0] & ien;
    elig[SRC_GEN]  = req_gen_i & ien;
  end

  irqc_prio #(.N(NSRC), .IW(SRC_W)) u_prio (
    .elig (elig),
    .any  (any),
    .idx  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      src_o     <= '0;
      vec_o     <= '0;
      gen_ack_o <= 1'b0;
    end else begin
      take_o    <= accept;
      gen_ack_o <= accept && win == SRC_GEN;
      if (accept) begin
        src_o <= win_idx;
        vec_o <= vec_of(win);
      end
    end
  end

  assign status_o = {1'b0, edge_pend, req_lvl_a_i, req_lvl_b_i, ien, mask};
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_nmi_i,
  input logic              boundary_i,
  input logic [DATA_W-1:0] status_o,
  input logic              take_o,
  input logic [SRC_W-1:0]  src_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              gen_ack_o
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i)); // R10
  AST_TAKE_DROPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !status_o[3]); // R9
  AST_MASKABLE_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o != SRC_NMI) |-> $past(status_o[3])); // R11
  AST_EDGE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == SRC_EDGE) |-> !$past(status_o[2])); // R11
  AST_NMI_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == SRC_NMI) |-> $past(req_nmi_i)); // R6
  AST_ACK_ONLY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack_o |-> (take_o && src_o == SRC_GEN && vec_o == '0)); // R8
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o || $past(boundary_i)); // R8
endmodule

bind irqc_top irqc_chk chk_i (.*);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  import irqc_pkg::*;

  logic clk = 0;
  logic rst_n = 0;
  logic req_nmi = 0, req_edge = 0, req_a = 0, req_b = 0, req_gen = 0;
  logic boundary = 0, ien_set = 0, ien_clr = 0, mask_wr = 0;
  logic [7:0]  mask_data = 0;
  logic [7:0]  status;
  logic        take;
  logic [2:0]  src;
  logic [15:0] vec;
  logic        gen_ack;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    bit        take;
    bit [2:0]  src;
    bit [15:0] vec;
    bit        ack;
    string     tag;
  } exp_t;
  exp_t q[$];
  logic bnd_q = 0;

  always #5 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_nmi_i(req_nmi), .req_edge_i(req_edge),
    .req_lvl_a_i(req_a), .req_lvl_b_i(req_b), .req_gen_i(req_gen),
    .boundary_i(boundary), .ien_set_i(ien_set), .ien_clr_i(ien_clr),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .status_o(status), .take_o(take), .src_o(src), .vec_o(vec),
    .gen_ack_o(gen_ack)
  );

  function automatic bit [15:0] exp_vec(bit [2:0] s);
    case (s)
      3'd0: return 16'h0024;
      3'd1: return 16'h003C;
      3'd2: return 16'h0034;
      3'd3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) bnd_q <= boundary;

  // monitor: compares outputs against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bnd_q) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (take !== e.take || gen_ack !== e.ack ||
            (e.take && (src !== e.src || vec !== e.vec))) begin
          n_fail++;
          $display("FAIL %s: take=%0b src=%0d vec=%h ack=%0b expected take=%0b src=%0d vec=%h ack=%0b",
                   e.tag, take, src, vec, gen_ack, e.take, e.src, e.vec, e.ack);
        end
      end else if (rst_n && take !== 1'b0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R10: take=%0b without boundary, expected 0", take);
      end
    end
  end

  task automatic sample(input bit t, input bit [2:0] s, input string tag);
    exp_t e;
    e.take = t; e.src = s; e.vec = t ? exp_vec(s) : 16'h0;
    e.ack  = t && s == 3'd4; e.tag = tag;
    @(negedge clk);
    q.push_back(e);
    boundary = 1;
    @(negedge clk);
    boundary = 0;
  endtask

  task automatic chk_status(input bit [7:0] e, input string tag);
    @(negedge clk);
    n_chk++;
    if (status !== e) begin
      n_fail++;
      $display("FAIL %s: status=%h expected %h", tag, status, e);
    end
  endtask

  task automatic p_set();  @(negedge clk); ien_set = 1; @(negedge clk); ien_set = 0; endtask
  task automatic wr_mask(input bit [7:0] d);
    @(negedge clk); mask_wr = 1; mask_data = d; @(negedge clk); mask_wr = 0;
  endtask
  task automatic pulse_edge(); @(negedge clk); req_edge = 1; @(negedge clk); req_edge = 0; endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_status(8'h07, "R1 reset status");
    sample(0, 0, "R1 no request after reset");
    // R2 enable strobes
    p_set();
    chk_status(8'h0F, "R2 set");
    @(negedge clk); ien_set = 1; ien_clr = 1; @(negedge clk); ien_set = 0; ien_clr = 0;
    chk_status(8'h07, "R2 clear wins");
    p_set();
    // R3 mask load and ignored write
    wr_mask(8'h08);
    chk_status(8'h08, "R3 unmask all");
    wr_mask(8'h07);
    chk_status(8'h08, "R3 write without load bit ignored");
    // R5 level A
    req_a = 1;
    chk_status(8'h28, "R5 level A visible");
    sample(1, 3'd2, "R5 R8 level A taken");
    chk_status(8'h20, "R9 enable cleared by acceptance");
    sample(0, 0, "R11 disabled level A not taken");
    req_a = 0;
    // R4 edge latch
    pulse_edge();
    chk_status(8'h40, "R4 edge latched after input fell");
    p_set();
    sample(1, 3'd1, "R4 R8 edge taken");
    chk_status(8'h00, "R9 latch and enable cleared");
    // R7 priority
    p_set();
    req_a = 1; req_b = 1; req_gen = 1;
    pulse_edge();
    sample(1, 3'd1, "R7 edge over all");
    p_set();
    sample(1, 3'd2, "R7 level A over B and general");
    req_a = 0; p_set();
    sample(1, 3'd3, "R7 level B over general");
    req_b = 0; p_set();
    sample(1, 3'd4, "R7 R8 general acknowledged");
    req_gen = 0;
    // R6 non-maskable, enable is 0 now
    @(negedge clk); req_nmi = 1;
    sample(1, 3'd0, "R6 nmi while disabled");
    sample(0, 0, "R6 held nmi not taken twice");
    @(negedge clk); req_nmi = 0;
    @(negedge clk); req_nmi = 1; @(negedge clk); req_nmi = 0;
    sample(0, 0, "R6 nmi fell before boundary");
    wr_mask(8'h0F);
    @(negedge clk); req_nmi = 1;
    sample(1, 3'd0, "R6 nmi ignores masks");
    @(negedge clk); req_nmi = 0;
    // R7 nmi beats pending edge
    wr_mask(8'h08);
    pulse_edge(); p_set();
    @(negedge clk); req_nmi = 1;
    sample(1, 3'd0, "R7 nmi over edge");
    req_nmi = 0;
    chk_status(8'h40, "R7 edge still pending");
    // R11 masked edge, R3 latch clear
    wr_mask(8'h0C); p_set();
    sample(0, 0, "R11 masked edge not taken");
    chk_status(8'h4C, "R11 edge kept, enable kept");
    wr_mask(8'h18);
    chk_status(8'h08, "R3 clear bit drops latch");
    // R10 no boundary
    req_b = 1;
    repeat (6) @(negedge clk);
    chk_status(8'h18, "R10 pending but untaken");
    sample(1, 3'd3, "R10 taken once boundary comes");
    req_b = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule